// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Access Unit

This block sits between a host processor bus and the internal register storage of a multi-channel serial controller. The host drives an active-low chip select, read and write strobes, an active-low interrupt-acknowledge input, an address and a write data byte. The block returns read data with a separate output enable, which is the bus modelled as split data-in, data-out and enable signals. It also returns an active-low data acknowledge. Every strobe is brought into the internal clock domain through a two-flop synchronizer, and all timing decisions are made on internal clock edges.

Two bus styles share the same logic. In the handshake style the acknowledge is enabled. It asserts on the second internal clock edge after a cycle is recognised, and a write lands in storage at the earlier of the acknowledge asserting or the write strobes ending. In the strobe-timed style the acknowledge is disabled by a control input and held high, so a write lands only when the strobes end. Read data is enabled for as long as both chip select and read are seen asserted.

The sequencer has four states. IDLE waits for a cycle to start. COUNT1 and COUNT2 count the two internal edges. ACKED holds the acknowledge. The transitions are as follows. IDLE goes to COUNT1 when chip select is seen together with any of read, write or interrupt acknowledge. COUNT1 goes to COUNT2, and COUNT2 goes to ACKED, on each edge while the cycle stays live. ACKED stays in ACKED while the cycle is live. Every state other than IDLE returns to IDLE as soon as the cycle ends.

Top module: `hostbus_if`

## Requirements
- R1: A bus cycle starts when synchronized chip select is low together with any one of read, write or interrupt acknowledge low; an interrupt-acknowledge-only cycle is acknowledged like any other.
- R2: With the acknowledge enabled, if the strobes fall just after a rising edge and stay low, ack_n is still high after the 4th rising edge and is low after the 5th (two synchronizer edges, one start-detect edge, two counted edges).
- R3: With the acknowledge enabled, a write stores the data byte held while the acknowledge asserts; a change on din after ack_n is low does not alter the stored byte.
- R4: With the acknowledge disabled, a write stores the last data byte sampled while chip select and write were seen low, committed once they are seen released; a write shorter than the acknowledge delay also commits this way in either style.
- R5: dout_oe is low after the 1st and high after the 2nd rising edge following chip select and read going low; while dout_oe is high, dout holds the stored byte at addr.
- R6: dout_oe is still high after the 1st and low after the 2nd rising edge following chip select or read going high.
- R7: With ack_en low, ack_n stays high throughout every cycle.
- R8: A cycle commits at most one write: in the handshake style with a late data change, the byte present at the acknowledge is what remains after the cycle ends.
- R9: After chip select is released, ack_n is still low after the 2nd rising edge and high after the 3rd.
- R10: An interrupt-acknowledge-only cycle writes no register and never raises dout_oe.
- R11: After reset, ack_n is high, dout_oe is low and every stored byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| iack_n | input | 1 | Interrupt acknowledge, active low, asynchronous |
| ack_en | input | 1 | 1 enables the data acknowledge (handshake style), 0 holds it off (strobe-timed style) |
| addr | input | AW | Register address |
| din | input | DW | Write data from the bus |
| dout | output | DW | Read data toward the bus |
| dout_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Data acknowledge, active low |

## Verification
Writes are tried with the data held steady, with the data changed after the acknowledge, and with strobes shorter than the acknowledge delay. These cases separate a commit made at the acknowledge from a commit made at strobe release, and they show whether a second commit slips in. Each pattern is repeated with the acknowledge enabled and disabled, so a design that ignores the control input or counts the wrong number of edges shows a different stored byte or a shifted ack_n. Interrupt-acknowledge-only cycles and random mixes of reads, writes and hold lengths from one to eight cycles are checked against a bench register model for read data, enable timing and acknowledge timing.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT1 = 2'd1,
        ST_COUNT2 = 2'd2,
        ST_ACKED  = 2'd3
    } hb_state_t;

    localparam int STROBE_CNT = 4;
    localparam int IDX_CS     = 0;
    localparam int IDX_RD     = 1;
    localparam int IDX_WR     = 2;
    localparam int IDX_IACK   = 3;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d_async[b]};
            end
        end

        assign q_sync[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic rd_s,
    input  logic wr_s,
    input  logic iack_s,
    input  logic ack_en,
    output logic ack_n,
    output logic commit
);

    hb_state_t state, state_nx;
    logic      live;
    logic      wr_cyc;
    logic      done;
    logic      wr_held;
    logic      ack_point;
    logic      end_point;

    assign live    = cs_s && (rd_s || wr_s || iack_s);
    assign wr_held = cs_s && wr_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (live)  state_nx = ST_COUNT1;
            ST_COUNT1: state_nx = live ? ST_COUNT2 : ST_IDLE;
            ST_COUNT2: state_nx = live ? ST_ACKED  : ST_IDLE;
            ST_ACKED:  if (!live) state_nx = ST_IDLE;
        endcase
    end

    // Per-cycle bookkeeping: write flag taken at start, one-shot commit guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cyc <= 1'b0;
            done   <= 1'b0;
        end else if (state == ST_IDLE) begin
            wr_cyc <= live && wr_s;
            done   <= 1'b0;
        end else if (commit) begin
            done   <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ack_point = (state == ST_COUNT2) && live && ack_en;
        end_point = (state != ST_IDLE) && !wr_held;
        commit    = wr_cyc && !done && (ack_point || end_point);
        ack_n     = !((state == ST_ACKED) && ack_en);
    end

endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          iack_n,
    input  logic          ack_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          ack_n
);

    logic [STROBE_CNT-1:0] strb_raw;
    logic [STROBE_CNT-1:0] strb_s;
    logic                  cs_s;
    logic                  rd_s;
    logic                  wr_s;
    logic                  iack_s;
    logic                  wr_commit;
    logic [AW-1:0]         addr_q;
    logic [DW-1:0]         data_q;

    always_comb begin
        strb_raw           = '0;
        strb_raw[IDX_CS]   = !cs_n;
        strb_raw[IDX_RD]   = !rd_n;
        strb_raw[IDX_WR]   = !wr_n;
        strb_raw[IDX_IACK] = !iack_n;
    end

    hb_sync #(.WIDTH(STROBE_CNT), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (strb_raw),
        .q_sync  (strb_s)
    );

    assign cs_s   = strb_s[IDX_CS];
    assign rd_s   = strb_s[IDX_RD];
    assign wr_s   = strb_s[IDX_WR];
    assign iack_s = strb_s[IDX_IACK];

    // Capture address and data while the write combination is seen active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (cs_s && wr_s) begin
            addr_q <= addr;
            data_q <= din;
        end
    end

    hb_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (cs_s),
        .rd_s   (rd_s),
        .wr_s   (wr_s),
        .iack_s (iack_s),
        .ack_en (ack_en),
        .ack_n  (ack_n),
        .commit (wr_commit)
    );

    hb_regfile #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr),
        .rdata (dout)
    );

    assign dout_oe = cs_s && rd_s;

endmodule

// File: rtl/hb_checker.sv
module hb_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic ack_en,
    input logic ack_n,
    input logic dout_oe,
    input logic cs_s,
    input logic wr_commit
);

    // R2: acknowledge falls only after chip select was seen for two edges
    assert_ack_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ($past(cs_s) && $past(cs_s, 2)));

    // R5: read enable only when both strobes were low two edges earlier
    assert_oe_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!$past(rd_n, 2) && !$past(cs_n, 2)));

    // R6: a released read or chip select turns the read enable off
    assert_oe_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_n, 2) || $past(cs_n, 2)) |-> !dout_oe);

    // R7: acknowledge held off while disabled
    assert_ack_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |-> ack_n);

    // R8: never two commits back to back
    assert_one_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R9: acknowledge released one edge after chip select is seen high
    assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> ack_n);

endmodule

bind hostbus_if hb_checker i_hb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .ack_en    (ack_en),
    .ack_n     (ack_n),
    .dout_oe   (dout_oe),
    .cs_s      (cs_s),
    .wr_commit (wr_commit)
);

// File: tb/test_hostbus_if.sv
`timescale 1ns/1ps
module test_hostbus_if;

    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int AW    = 6;
    localparam int K_RD  = 0;
    localparam int K_WR  = 1;
    localparam int K_IA  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iack_n = 1'b1;
    logic          ack_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          ack_n;

    logic [DW-1:0] model [DEPTH];
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    hostbus_if #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_hostbus_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .iack_n(iack_n), .ack_en(ack_en), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .ack_n(ack_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] stored_after(input int kind, input bit en, input bit alt,
                                                    input logic [DW-1:0] d, input logic [DW-1:0] d2,
                                                    input logic [DW-1:0] old);
        if (kind != K_WR) return old;
        if (alt && !en)   return d2;
        return d;
    endfunction

    // One bus cycle; alt changes din after the acknowledge point (needs hold >= 7)
    task automatic run_cycle(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit en, input int hold, input bit alt, input logic [DW-1:0] d2);
        bit acked;
        acked  = en && hold >= 5;
        ack_en = en;
        addr   = a;
        din    = d;
        cs_n   = 1'b0;
        rd_n   = (kind == K_RD) ? 1'b0 : 1'b1;
        wr_n   = (kind == K_WR) ? 1'b0 : 1'b1;
        iack_n = (kind == K_IA) ? 1'b0 : 1'b1;
        for (int k = 1; k <= hold; k++) begin
            step();
            if (kind == K_RD && k == 1) check(dout_oe == 1'b0, "R5 oe early", dout_oe, 0);
            if (kind == K_RD && k == 2) begin
                check(dout_oe == 1'b1, "R5 oe on", dout_oe, 1);
                check(dout == model[a], "R5 dout", dout, model[a]);
            end
            if (kind == K_IA && k == 2) check(dout_oe == 1'b0, "R10 no oe", dout_oe, 0);
            if (k == 4) check(ack_n == 1'b1, "R2 ack before 5th edge", ack_n, 1);
            if (k == 5) begin
                if (en) check(ack_n == 1'b0, (kind == K_IA) ? "R1 iack ack" : "R2 ack at 5th edge", ack_n, 0);
                else    check(ack_n == 1'b1, "R7 ack off", ack_n, 1);
                if (alt) din = d2;
            end
        end
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; iack_n = 1'b1;
        step();
        if (kind == K_RD) check(dout_oe == 1'b1, "R6 oe held", dout_oe, 1);
        step();
        if (kind == K_RD) check(dout_oe == 1'b0, "R6 oe off", dout_oe, 0);
        if (acked) check(ack_n == 1'b0, "R9 ack held", ack_n, 0);
        step();
        check(ack_n == 1'b1, "R9 ack released", ack_n, 1);
        step();
        step();
        model[a] = stored_after(kind, en, alt, d, d2, model[a]);
    endtask

    task automatic read_back(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a;
        cs_n = 1'b0; rd_n = 1'b0;
        step(); step(); step();
        check(dout == exp && dout_oe, req, dout, exp);
        cs_n = 1'b1; rd_n = 1'b1;
        step(); step(); step(); step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) step();
        check(ack_n == 1'b1, "R11 ack reset", ack_n, 1);
        check(dout_oe == 1'b0, "R11 oe reset", dout_oe, 0);
        rst_n = 1'b1;
        step();
        read_back(6'd0, 8'h00, "R11 reg0 reset");
        read_back(6'd63, 8'h00, "R11 reg63 reset");

        // R3 / R8: handshake write, data changed after acknowledge
        run_cycle(K_WR, 6'd10, 8'hA5, 1'b1, 8, 1'b1, 8'h3C);
        read_back(6'd10, 8'hA5, "R3 R8 data at ack kept");
        // R4: strobe-timed write, last data before release wins
        run_cycle(K_WR, 6'd11, 8'hA5, 1'b0, 8, 1'b1, 8'h3C);
        read_back(6'd11, 8'h3C, "R4 data at release");
        // R4: short write in handshake style
        run_cycle(K_WR, 6'd12, 8'h5A, 1'b1, 1, 1'b0, 8'h00);
        read_back(6'd12, 8'h5A, "R4 short write");
        // R1 / R10: interrupt-acknowledge-only cycle
        run_cycle(K_WR, 6'd5, 8'h11, 1'b1, 6, 1'b0, 8'h00);
        run_cycle(K_IA, 6'd5, 8'h99, 1'b1, 6, 1'b0, 8'h00);
        read_back(6'd5, 8'h11, "R10 iack no write");
        // R7: read with acknowledge disabled
        run_cycle(K_RD, 6'd5, 8'h00, 1'b0, 6, 1'b0, 8'h00);

        for (int n = 0; n < 300; n++) begin
            int            kind;
            int            hold;
            bit            en;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            kind = int'($urandom_range(2, 0));
            hold = int'($urandom_range(8, 1));
            en   = 1'($urandom_range(1, 0));
            a    = AW'($urandom_range(DEPTH - 1, 0));
            d    = DW'($urandom_range(255, 0));
            run_cycle(kind, a, d, en, hold, 1'b0, 8'h00);
        end
        for (int i = 0; i < DEPTH; i += 7) read_back(AW'(i), model[i], "R5 final sweep");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule